// File: doc/BRIEF.md
# Set/Clear/Toggle Aliased Register Bank

This block is the control and status register bank of a sensor peripheral. It sits on a simple synchronous bus with one address, one write-data word, a write strobe, a read strobe and a registered read-data word. All registers are 32 bits wide and word aligned. The control words drive neighbouring logic through output ports. A status word collects event flags raised by that logic, and a read-only sample register returns the latest signed sensor value.

Most registers decode four addresses. The base address takes a plain write. The three addresses above it apply a bitwise operation using only the bits written as one: +0x4 sets them, +0x8 clears them and +0xC flips them. Software can therefore change single fields without a read-modify-write. Status flags raised by hardware are acknowledged by writing ones to the clear alias. If an event and a clear land in the same cycle, the event wins, so no event is lost. The two trim words are plain registers with a reset default and no aliases.

Top module: `sct_regbank`

## Requirements
- R1: After reset every register output is zero, except `trim_a` and `trim_b`, which take the values of parameters `TRIM_A_RST` and `TRIM_B_RST`.
- R2: A write to the base address of an aliased register (control 0 at 0x000, status at 0x010, threshold at 0x030, control 1 at 0x200, period at 0x270, reference divider at 0x280, power-up delay at 0x2B0) replaces its value, visible on its output port one cycle later.
- R3: A write to base+0x4 ORs the write data into the register.
- R4: A write to base+0x8 ANDs the register with the inverse of the write data.
- R5: A write to base+0xC XORs the write data into the register.
- R6: A read captures a word into `rdata` at the clock edge where `rd_en` is high, and the word is visible the following cycle. The word is the register value before any write in that same cycle, and it is the same for the base address and each of its three aliases. When `rd_en` is low, `rdata` is zero.
- R7: Every bit of `sts_evt` that is also set in `STS_EVT_MASK` sets the matching status bit one cycle later. The bit stays set until software changes it. `sts_evt` bits outside the mask have no effect.
- R8: When a status event bit and a software clear (or toggle, or plain write of zero) of the same bit fall in one cycle, the bit ends up set.
- R9: The sample register at 0x020 (and its aliases) reads back `sample` sign-extended to 32 bits. Writes to any of its four addresses change no output.
- R10: The trim words at 0x2E0 and 0x2F0 take plain full-word writes at their base addresses only. Their +0x4, +0x8 and +0xC addresses are unmapped.
- R11: A write to an unmapped address, including any address with bits [1:0] not zero, changes no register, and a read from it returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (12) | Byte address, shared by reads and writes |
| wdata | input | DATA_W (32) | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | DATA_W (32) | Registered read data |
| sts_evt | input | DATA_W (32) | Status event pulses from neighbouring logic |
| sample | input | SAMPLE_W (16) | Signed sensor sample |
| ctl0 | output | DATA_W (32) | Control 0 word |
| sts0 | output | DATA_W (32) | Status word |
| thr | output | DATA_W (32) | Threshold word |
| ctl1 | output | DATA_W (32) | Control 1 word |
| period | output | DATA_W (32) | Measurement period word |
| refdiv | output | DATA_W (32) | Reference divider word |
| pud | output | DATA_W (32) | Power-up delay word |
| trim_a | output | DATA_W (32) | First trim word |
| trim_b | output | DATA_W (32) | Second trim word |

## Verification
The hardest case to reach is a status event that coincides with a software clear, toggle or zeroing write to the same flag. Random stimulus seldom lines these up on a chosen bit. Directed steps therefore drive an event on a masked bit in the very cycle of a clear-alias write of all ones, and again with a toggle. The random phase raises events one cycle in eight while it also targets the status aliases, so more coincidences occur. Trim aliases, misaligned addresses and sample-register writes are placed between reads, so that an ignored write would show up on the ports.

// File: rtl/sct_regbank_pkg.sv
package sct_regbank_pkg;

   // Register slots; the order also indexes the read word array.
   typedef enum logic [3:0] {
      IX_CTL0 = 4'd0,
      IX_STS0 = 4'd1,
      IX_DAT0 = 4'd2,
      IX_THR  = 4'd3,
      IX_CTL1 = 4'd4,
      IX_PER  = 4'd5,
      IX_RDIV = 4'd6,
      IX_PUD  = 4'd7,
      IX_TRMA = 4'd8,
      IX_TRMB = 4'd9,
      IX_NONE = 4'd15
   } reg_ix_e;

   // Encoding equals address bits [3:2] of the alias.
   typedef enum logic [1:0] {
      OP_PLAIN = 2'd0,
      OP_SET   = 2'd1,
      OP_CLR   = 2'd2,
      OP_TOG   = 2'd3
   } wr_op_e;

   localparam int NUM_REGS = 10;

   localparam int OFS_CTL0 = 'h000;
   localparam int OFS_STS0 = 'h010;
   localparam int OFS_DAT0 = 'h020;
   localparam int OFS_THR  = 'h030;
   localparam int OFS_CTL1 = 'h200;
   localparam int OFS_PER  = 'h270;
   localparam int OFS_RDIV = 'h280;
   localparam int OFS_PUD  = 'h2B0;
   localparam int OFS_TRMA = 'h2E0;
   localparam int OFS_TRMB = 'h2F0;

   localparam int OFS_MAX  = OFS_TRMB + 'hC;

   // Slots that decode the three write aliases.
   function automatic bit has_alias(int ix);
      return !(ix == int'(IX_TRMA) || ix == int'(IX_TRMB));
   endfunction

endpackage

// File: rtl/sct_addr_dec.sv
module sct_addr_dec
   import sct_regbank_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_ix_e           ix,
   output wr_op_e            op
);

   logic [ADDR_W-1:0] base;
   logic              aligned;
   logic              at_base;

   assign base    = {addr[ADDR_W-1:4], 4'h0};
   assign aligned = (addr[1:0] == 2'b00);
   assign at_base = (addr[3:2] == 2'b00);
   assign op      = wr_op_e'(addr[3:2]);

   always_comb begin
      ix = IX_NONE;
      if (aligned) begin
         if      (base == ADDR_W'(OFS_CTL0)) ix = IX_CTL0;
         else if (base == ADDR_W'(OFS_STS0)) ix = IX_STS0;
         else if (base == ADDR_W'(OFS_DAT0)) ix = IX_DAT0;
         else if (base == ADDR_W'(OFS_THR))  ix = IX_THR;
         else if (base == ADDR_W'(OFS_CTL1)) ix = IX_CTL1;
         else if (base == ADDR_W'(OFS_PER))  ix = IX_PER;
         else if (base == ADDR_W'(OFS_RDIV)) ix = IX_RDIV;
         else if (base == ADDR_W'(OFS_PUD))  ix = IX_PUD;
         else if (base == ADDR_W'(OFS_TRMA) && at_base) ix = IX_TRMA;
         else if (base == ADDR_W'(OFS_TRMB) && at_base) ix = IX_TRMB;
      end
   end

endmodule

// File: rtl/sct_alias_reg.sv
module sct_alias_reg
   import sct_regbank_pkg::*;
#(
   parameter int               DATA_W   = 32,
   parameter logic [DATA_W-1:0] RST_VAL  = '0,
   parameter logic [DATA_W-1:0] EVT_MASK = '0,
   parameter bit               ALIAS_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_sel,
   input  wr_op_e            op,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] evt,
   output logic [DATA_W-1:0] q
);

   logic [DATA_W-1:0] sw_nxt;
   logic [DATA_W-1:0] nxt;

   generate
      if (ALIAS_EN) begin : g_alias
         always_comb begin
            sw_nxt = q;
            if (wr_sel) begin
               unique case (op)
                  OP_PLAIN: sw_nxt = wdata;
                  OP_SET:   sw_nxt = q | wdata;
                  OP_CLR:   sw_nxt = q & ~wdata;
                  OP_TOG:   sw_nxt = q ^ wdata;
                  default:  sw_nxt = q;
               endcase
            end
         end
      end else begin : g_plain
         always_comb begin
            sw_nxt = q;
            if (wr_sel && op == OP_PLAIN) sw_nxt = wdata;
         end
      end
   endgenerate

   // Hardware events are merged after the software update so they win.
   assign nxt = sw_nxt | (evt & EVT_MASK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= nxt;
   end

endmodule

// File: rtl/sct_rd_mux.sv
module sct_rd_mux
   import sct_regbank_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int SAMPLE_W      = 16,
   parameter bit SAMPLE_SIGNED = 1'b1
) (
   input  reg_ix_e                          ix,
   input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs,
   input  logic [SAMPLE_W-1:0]              sample,
   output logic [DATA_W-1:0]                word
);

   localparam int EXT_W = DATA_W - SAMPLE_W;

   logic [DATA_W-1:0] sample_ext;

   generate
      if (EXT_W == 0) begin : g_full
         assign sample_ext = sample;
      end else if (SAMPLE_SIGNED) begin : g_sext
         assign sample_ext = {{EXT_W{sample[SAMPLE_W-1]}}, sample};
      end else begin : g_zext
         assign sample_ext = {{EXT_W{1'b0}}, sample};
      end
   endgenerate

   always_comb begin
      word = '0;
      if (ix == IX_DAT0)                 word = sample_ext;
      else if (int'(ix) < NUM_REGS)      word = regs[ix];
   end

endmodule

// File: rtl/sct_regbank.sv
module sct_regbank
   import sct_regbank_pkg::*;
#(
   parameter int                ADDR_W        = 12,
   parameter int                DATA_W        = 32,
   parameter int                SAMPLE_W      = 16,
   parameter bit                SAMPLE_SIGNED = 1'b1,
   parameter logic [DATA_W-1:0] STS_EVT_MASK  = 32'h0001_0200,
   parameter logic [DATA_W-1:0] TRIM_A_RST    = 32'hA5C3_0F1E,
   parameter logic [DATA_W-1:0] TRIM_B_RST    = 32'h0000_4D2B
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   input  logic                wr_en,
   input  logic                rd_en,
   output logic [DATA_W-1:0]   rdata,
   input  logic [DATA_W-1:0]   sts_evt,
   input  logic [SAMPLE_W-1:0] sample,
   output logic [DATA_W-1:0]   ctl0,
   output logic [DATA_W-1:0]   sts0,
   output logic [DATA_W-1:0]   thr,
   output logic [DATA_W-1:0]   ctl1,
   output logic [DATA_W-1:0]   period,
   output logic [DATA_W-1:0]   refdiv,
   output logic [DATA_W-1:0]   pud,
   output logic [DATA_W-1:0]   trim_a,
   output logic [DATA_W-1:0]   trim_b
);

   localparam int ADDR_MIN = $clog2(OFS_MAX + 1);

   initial begin
      assert (ADDR_W >= ADDR_MIN)
         else $error("ADDR_W too narrow for the register map");
      assert (DATA_W == 32)
         else $error("register map assumes 32-bit words");
      assert (SAMPLE_W >= 2 && SAMPLE_W <= DATA_W)
         else $error("SAMPLE_W out of range");
   end

   reg_ix_e                         ix;
   wr_op_e                          op;
   logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
   logic [DATA_W-1:0]               rd_word;

   sct_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
      .addr (addr),
      .ix   (ix),
      .op   (op)
   );

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
         if (g == int'(IX_DAT0)) begin : g_ro
            assign regs_q[g] = '0;
         end else begin : g_rw
            localparam logic [DATA_W-1:0] RV =
               (g == int'(IX_TRMA)) ? TRIM_A_RST :
               (g == int'(IX_TRMB)) ? TRIM_B_RST : {DATA_W{1'b0}};
            localparam logic [DATA_W-1:0] MSK =
               (g == int'(IX_STS0)) ? STS_EVT_MASK : {DATA_W{1'b0}};
            sct_alias_reg #(
               .DATA_W   (DATA_W),
               .RST_VAL  (RV),
               .EVT_MASK (MSK),
               .ALIAS_EN (has_alias(g))
            ) u_reg (
               .clk    (clk),
               .rst_n  (rst_n),
               .wr_sel (wr_en && (ix == reg_ix_e'(g))),
               .op     (op),
               .wdata  (wdata),
               .evt    (sts_evt),
               .q      (regs_q[g])
            );
         end
      end
   endgenerate

   sct_rd_mux #(
      .DATA_W        (DATA_W),
      .SAMPLE_W      (SAMPLE_W),
      .SAMPLE_SIGNED (SAMPLE_SIGNED)
   ) u_rd (
      .ix     (ix),
      .regs   (regs_q),
      .sample (sample),
      .word   (rd_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_word;
      else            rdata <= '0;
   end

   assign ctl0   = regs_q[IX_CTL0];
   assign sts0   = regs_q[IX_STS0];
   assign thr    = regs_q[IX_THR];
   assign ctl1   = regs_q[IX_CTL1];
   assign period = regs_q[IX_PER];
   assign refdiv = regs_q[IX_RDIV];
   assign pud    = regs_q[IX_PUD];
   assign trim_a = regs_q[IX_TRMA];
   assign trim_b = regs_q[IX_TRMB];

endmodule

// File: rtl/sct_regbank_chk.sv
module sct_regbank_chk
   import sct_regbank_pkg::*;
#(
   parameter int                ADDR_W       = 12,
   parameter int                DATA_W       = 32,
   parameter int                SAMPLE_W     = 16,
   parameter logic [DATA_W-1:0] STS_EVT_MASK = '0
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   addr,
   input logic [DATA_W-1:0]   wdata,
   input logic                wr_en,
   input logic                rd_en,
   input logic [DATA_W-1:0]   rdata,
   input logic [DATA_W-1:0]   sts_evt,
   input logic [SAMPLE_W-1:0] sample,
   input logic [DATA_W-1:0]   ctl0,
   input logic [DATA_W-1:0]   sts0,
   input logic [DATA_W-1:0]   ctl1,
   input logic [DATA_W-1:0]   trim_a
);

   logic [DATA_W-1:0] evt_m;
   assign evt_m = sts_evt & STS_EVT_MASK;

   // R3
   set_alias_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFS_CTL1 + 'h4))
      |=> ((ctl1 & $past(wdata)) == $past(wdata)));

   // R4
   clr_alias_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFS_CTL0 + 'h8))
      |=> ((ctl0 & $past(wdata)) == '0));

   // R6
   idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rdata == '0));

   // R7
   evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_m != '0) |=> ((sts0 & $past(evt_m)) == $past(evt_m)));

   // R8
   evt_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFS_STS0 + 'h8) && evt_m != '0)
      |=> ((sts0 & $past(evt_m)) == $past(evt_m)));

   // R10
   trim_alias_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFS_TRMA + 'h4)) |=> $stable(trim_a));

   // R11
   misaligned_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr[1:0] != 2'b00)
      |=> ($stable(ctl0) && $stable(ctl1) && $stable(trim_a)));

   // R9
   sample_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(OFS_DAT0))
      |=> (rdata[SAMPLE_W-1:0] == $past(sample)));

endmodule

bind sct_regbank sct_regbank_chk #(
   .ADDR_W       (ADDR_W),
   .DATA_W       (DATA_W),
   .SAMPLE_W     (SAMPLE_W),
   .STS_EVT_MASK (STS_EVT_MASK)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .addr    (addr),
   .wdata   (wdata),
   .wr_en   (wr_en),
   .rd_en   (rd_en),
   .rdata   (rdata),
   .sts_evt (sts_evt),
   .sample  (sample),
   .ctl0    (ctl0),
   .sts0    (sts0),
   .ctl1    (ctl1),
   .trim_a  (trim_a)
);

// File: tb/sct_regbank_bench.sv
module sct_regbank_bench;

   localparam logic [31:0] MASK  = 32'h0001_0200;
   localparam logic [31:0] TA_RV = 32'hA5C3_0F1E;
   localparam logic [31:0] TB_RV = 32'h0000_4D2B;
   localparam int          NRAND = 3000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [31:0] rdata;
   logic [31:0] sts_evt = '0;
   logic [15:0] sample = '0;
   logic [31:0] ctl0, sts0, thr, ctl1, period, refdiv, pud, trim_a, trim_b;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [31:0] mdl [10];

   always #2 clk = ~clk;

   sct_regbank #(
      .ADDR_W(12), .DATA_W(32), .SAMPLE_W(16), .SAMPLE_SIGNED(1'b1),
      .STS_EVT_MASK(MASK), .TRIM_A_RST(TA_RV), .TRIM_B_RST(TB_RV)
   ) u_sct_regbank (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
      .rd_en(rd_en), .rdata(rdata), .sts_evt(sts_evt), .sample(sample),
      .ctl0(ctl0), .sts0(sts0), .thr(thr), .ctl1(ctl1), .period(period),
      .refdiv(refdiv), .pud(pud), .trim_a(trim_a), .trim_b(trim_b)
   );

   // Slot index: 0 ctl0, 1 sts0, 2 sample, 3 thr, 4 ctl1, 5 period,
   // 6 refdiv, 7 pud, 8 trim_a, 9 trim_b; -1 unmapped.
   function automatic int dec_ix(logic [11:0] a);
      if (a[1:0] != 2'b00) return -1;
      case ({a[11:4], 4'h0})
         12'h000: return 0;
         12'h010: return 1;
         12'h020: return 2;
         12'h030: return 3;
         12'h200: return 4;
         12'h270: return 5;
         12'h280: return 6;
         12'h2B0: return 7;
         12'h2E0: return (a[3:2] == 2'b00) ? 8 : -1;
         12'h2F0: return (a[3:2] == 2'b00) ? 9 : -1;
         default: return -1;
      endcase
   endfunction

   function automatic logic [31:0] apply(logic [1:0] k, logic [31:0] q, logic [31:0] w);
      case (k)
         2'd0:    return w;
         2'd1:    return q | w;
         2'd2:    return q & ~w;
         default: return q ^ w;
      endcase
   endfunction

   function automatic string tag_of(bit we, logic [11:0] a);
      int ix;
      ix = dec_ix(a);
      if (!we) return "R7";
      if (ix < 0) return ((a[11:4] == 8'h2E || a[11:4] == 8'h2F) && a[1:0] == 2'b00) ? "R10" : "R11";
      if (ix == 2) return "R9";
      if (ix >= 8) return "R10";
      if (ix == 1) return "R8";
      case (a[3:2])
         2'd0:    return "R2";
         2'd1:    return "R3";
         2'd2:    return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic chk_regs(string tag);
      chk(tag, "ctl0",   ctl0,   mdl[0]);
      chk(tag, "sts0",   sts0,   mdl[1]);
      chk(tag, "thr",    thr,    mdl[3]);
      chk(tag, "ctl1",   ctl1,   mdl[4]);
      chk(tag, "period", period, mdl[5]);
      chk(tag, "refdiv", refdiv, mdl[6]);
      chk(tag, "pud",    pud,    mdl[7]);
      chk(tag, "trim_a", trim_a, mdl[8]);
      chk(tag, "trim_b", trim_b, mdl[9]);
   endtask

   task automatic step(logic [11:0] a, logic [31:0] w, bit we, bit re,
                       logic [31:0] ev, logic [15:0] smp);
      int          ix;
      logic [31:0] exp_rd;
      string       rtag;
      @(negedge clk);
      addr = a; wdata = w; wr_en = we; rd_en = re; sts_evt = ev; sample = smp;
      ix = dec_ix(a);
      exp_rd = '0;
      if (re && ix == 2)      exp_rd = {{16{smp[15]}}, smp};
      else if (re && ix >= 0) exp_rd = mdl[ix];
      rtag = (ix == 2) ? "R9" : (ix < 0 ? "R11" : "R6");
      if (we && ix >= 0 && ix != 2) mdl[ix] = apply(a[3:2], mdl[ix], w);
      mdl[1] = mdl[1] | (ev & MASK);
      @(posedge clk);
      #1;
      chk(rtag, "rdata", rdata, exp_rd);
      chk_regs(tag_of(we, a));
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      foreach (mdl[i]) mdl[i] = '0;
      mdl[8] = TA_RV;
      mdl[9] = TB_RV;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset values
      chk_regs("R1");
      chk("R1", "rdata", rdata, '0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2 plain write, R3 set, R4 clear, R5 toggle on control 1
      step(12'h200, 32'hF0F0_1234, 1, 0, '0, '0);
      step(12'h204, 32'h0000_000F, 1, 0, '0, '0);
      step(12'h208, 32'hF000_0004, 1, 0, '0, '0);
      step(12'h20C, 32'hFFFF_0000, 1, 0, '0, '0);
      // R6 same value from base and each alias, and the pre-write value
      step(12'h200, '0, 0, 1, '0, '0);
      step(12'h204, '0, 0, 1, '0, '0);
      step(12'h20C, 32'h1, 1, 1, '0, '0);
      step(12'h208, '0, 0, 1, '0, '0);
      // R7 event sets masked flag, unmasked bit ignored
      step(12'h000, '0, 0, 0, 32'h0000_0201, '0);
      step(12'h010, '0, 0, 1, '0, '0);
      // R8 event beats clear and toggle in the same cycle
      step(12'h018, 32'hFFFF_FFFF, 1, 0, 32'h0001_0000, '0);
      step(12'h01C, 32'h0001_0200, 1, 0, 32'h0001_0000, '0);
      step(12'h010, 32'h0, 1, 0, 32'h0000_0200, '0);
      step(12'h018, 32'hFFFF_FFFF, 1, 0, '0, '0);
      // R9 sample read sign-extended, writes ignored
      step(12'h020, 32'hDEAD_BEEF, 1, 1, '0, 16'h8003);
      step(12'h024, 32'hFFFF_FFFF, 1, 1, '0, 16'h7FFE);
      step(12'h02C, 32'hFFFF_FFFF, 1, 1, '0, 16'hFFFF);
      // R10 trim plain writes and ignored aliases
      step(12'h2E0, 32'h1357_9BDF, 1, 1, '0, '0);
      step(12'h2E4, 32'hFFFF_FFFF, 1, 1, '0, '0);
      step(12'h2F8, 32'hFFFF_FFFF, 1, 1, '0, '0);
      step(12'h2F0, 32'h0BAD_F00D, 1, 0, '0, '0);
      // R11 misaligned and unmapped addresses
      step(12'h201, 32'hFFFF_FFFF, 1, 1, '0, '0);
      step(12'h100, 32'hFFFF_FFFF, 1, 1, '0, '0);
      step(12'hFFC, 32'hFFFF_FFFF, 1, 1, '0, '0);

      for (int n = 0; n < NRAND; n++) begin
         logic [11:0] bases [10];
         logic [11:0] a;
         logic [31:0] ev;
         int          r;
         bases = '{12'h000, 12'h010, 12'h020, 12'h030, 12'h200,
                   12'h270, 12'h280, 12'h2B0, 12'h2E0, 12'h2F0};
         r = int'($urandom % 16);
         if (r < 13) a = bases[$urandom % 10] + 12'(($urandom % 4) * 4);
         else        a = 12'($urandom);
         ev = (($urandom % 8) == 0) ? $urandom : 32'h0;
         step(a, $urandom, bit'($urandom % 2), bit'($urandom % 2), ev, 16'($urandom));
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule